// File: doc/BRIEF.md
# Programmable 16-bit Root Timer Channel

This block is one 16-bit timer channel. It has three registers on a simple register bus: a count, a mode and a target. A channel-number parameter (0, 1 or 2) fixes which alternate clock source the channel may use:

- Channel 0 can count on a pixel-clock enable.
- Channel 1 can count on a horizontal-sync pulse.
- Channel 2 has no alternate source. Instead it can divide the system clock enable by eight, and it has a stop bit.

The count advances on the selected enable. It can either fold back to zero after it reaches the target, or run on through the target to a 16-bit wrap. On a target event or an overflow event the channel raises a one-cycle interrupt pulse on its own bit of an interrupt vector. The mode register chooses whether that pulse is issued only once after each mode write or on every qualifying event.

Sticky status flags in the mode register record target and overflow events. Software reads the mode register to learn which event happened, and that read clears the two flags. Writing the mode register restarts the channel: the count goes to zero, the flags clear and the one-shot interrupt latch is re-armed. Gate and sync modes are not part of this block.

Register map (`bus_addr`): 0 = count, 1 = mode, 2 = target, 3 = reads zero. Reads are registered: `bus_rdata` holds the result in the cycle after the read strobe.

Mode layout:

| Bit | Meaning |
|---|---|
| 0 | Stop (channel 2 only) |
| 3 | Reset the count at the target |
| 4 | Interrupt on a target event |
| 5 | Interrupt on an overflow event |
| 6 | Repeat interrupt |
| 8 | Alternate clock |
| 9 | Divide by eight (channel 2 only) |
| 10 | Any-event flag |
| 11 | Target flag |
| 12 | Overflow flag |
| 13–15 | Read as zero |

Top module: `prog_root_timer`

## Requirements
- R1: After reset, the count, mode and target registers read 0 and no interrupt bit is high.
- R2: With mode bit 8 clear (and on channel 2 with bits 0 and 9 clear), the count rises by one on every cycle with `sys_ce` high and holds otherwise.
- R3: A count write keeps only the low 16 bits of the 32-bit data. A target write is read back exactly, zero-extended. Address 3 reads 0.
- R4: A target event happens on the tick where the count becomes equal to the target. It sets mode bits 11 and 10. With mode bit 3 set, the next tick loads 0, so the count runs 0..target. With bit 3 clear, the count passes the target.
- R5: An overflow event is the tick that steps the count from 0xFFFF to 0 (unless a reset at the target takes that step). It sets mode bits 12 and 10.
- R6: A qualifying event (target with mode bit 4, overflow with mode bit 5) gives a one-cycle high on `irq_vec` bit 4+channel, in the cycle after the tick. No other `irq_vec` bit is ever set.
- R7: With mode bit 6 clear, only the first qualifying event after a mode write gives a pulse. With bit 6 set, every qualifying event gives one.
- R8: A mode read returns the current mode value and then clears bits 11 and 12. Bit 10 stays set. An event in the same cycle as the read leaves its flag set.
- R9: A mode write stores bits 9:0, forces the count to 0, clears bits 10–12 and re-arms the one-shot latch. Bits 13–15 always read 0.
- R10: Mode bit 8 makes channel 0 count on `pix_ce` and channel 1 count on `hsync_pulse`, in place of `sys_ce`. On channel 2, bit 8 has no effect on counting.
- R11: On channel 2, mode bit 9 gives one tick per eight `sys_ce` cycles, the first on the eighth after a mode write. Mode bit 0 stops counting.
- R12: A count or mode write in the same cycle as a tick takes priority: the tick is lost and no event results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| sys_ce | input | 1 | System clock enable |
| pix_ce | input | 1 | Pixel clock enable (alternate source, channel 0) |
| hsync_pulse | input | 1 | One-cycle horizontal sync pulse (alternate source, channel 1) |
| irq_vec | output | 8 | Interrupt vector; this channel drives only bit 4+channel |

## Verification
The bench targets several corner cases, and each has a visible symptom if the design gets it wrong:

- **Fold-back point.** The count is read at the target and one tick later. A design that reloaded on the match tick itself would skip the target value.
- **Target that is passed.** A design that reloaded with mode bit 3 clear would read back too low.
- **0xFFFE to 0 wrap.** This is checked together with the overflow flag.
- **Same-cycle read and target event.** A design that let the read-clear win would lose the event.
- **Count or mode write together with a tick.** A design that let the tick win would read one too high.
- **Interrupt counts.** The bench counts pulses in one-shot and repeat modes, before and after a re-arming mode write. A latch that was never re-armed, or a pulse more than one cycle wide, changes the count.
- **Channel-specific behaviour.** Three instances check the alternate sources, the divide-by-eight phase after a mode write, and the stop bit.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

  // Mode register field positions (software-visible layout).
  localparam int MB_STOP    = 0;
  localparam int MB_RST_TGT = 3;
  localparam int MB_IRQ_TGT = 4;
  localparam int MB_IRQ_OVF = 5;
  localparam int MB_IRQ_RPT = 6;
  localparam int MB_ALT     = 8;
  localparam int MB_DIV     = 9;
  localparam int MB_EVT     = 10;
  localparam int MB_FLG_TGT = 11;
  localparam int MB_FLG_OVF = 12;

  localparam int MODE_W = 16;  // visible mode width
  localparam int CFG_W  = 10;  // writable control bits 9:0

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_MODE   = 2'd1,
    REG_TARGET = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic tgt;
    logic ovf;
  } evt_t;

endpackage

// File: rtl/rtmr_clk_sel.sv
module rtmr_clk_sel #(
  parameter int CHAN_IDX = 0,
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic ctl_stop,
  input  logic ctl_alt,
  input  logic ctl_div,
  input  logic sys_ce,
  input  logic pix_ce,
  input  logic hsync_pulse,
  output logic tick
);

  logic unused_src;

  generate
    if (CHAN_IDX == 2) begin : g_div
      logic [DIV_LOG2-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || mode_wr) pre_q <= '0;
        else if (sys_ce)    pre_q <= pre_q + 1'b1;
      end

      assign tick       = !ctl_stop && sys_ce && (!ctl_div || (&pre_q));
      assign unused_src = pix_ce ^ hsync_pulse ^ ctl_alt;

      // R11: a divided tick is never followed directly by another
      assert_div_spacing_R11: assert property (@(posedge clk) disable iff (rst)
        (tick && ctl_div && !mode_wr) |=> !tick)
        else $error("divided tick repeated on consecutive cycles");
    end else if (CHAN_IDX == 1) begin : g_hsync
      assign tick       = ctl_alt ? hsync_pulse : sys_ce;
      assign unused_src = pix_ce ^ ctl_stop ^ ctl_div ^ mode_wr ^ rst ^ clk;
    end else begin : g_pix
      assign tick       = ctl_alt ? pix_ce : sys_ce;
      assign unused_src = hsync_pulse ^ ctl_stop ^ ctl_div ^ mode_wr ^ rst ^ clk;
    end
  endgenerate

endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             rst_at_tgt,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt_q,
  output evt_t             evt
);

  logic [CNT_W-1:0] nxt;
  logic             fold;
  logic             live;

  always_comb begin
    fold    = rst_at_tgt && (cnt_q == target);
    nxt     = fold ? '0 : cnt_q + 1'b1;
    live    = tick && !cnt_wr && !clr;
    evt.tgt = live && (nxt == target);
    evt.ovf = live && (&cnt_q) && !fold;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (tick)   cnt_q <= nxt;
  end

  assert_ovf_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    evt.ovf |=> (cnt_q == '0))
    else $error("overflow event did not leave count at zero");

  assert_tgt_lands_R4: assert property (@(posedge clk) disable iff (rst)
    evt.tgt |=> (cnt_q == $past(target)))
    else $error("target event without count reaching target");

  assert_mode_clears_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0))
    else $error("mode write did not zero the count");

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !clr) |=> (cnt_q == $past(cnt_wdata)))
    else $error("count write lost against a tick");

endmodule

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
  import rtmr_pkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int IRQ_W    = 8,
  parameter int IRQ_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [CFG_W-1:0]  mode_wdata,
  input  logic              mode_rd,
  input  evt_t              evt_in,
  output logic [MODE_W-1:0] mode_q,
  output logic [IRQ_W-1:0]  irq_vec
);

  localparam int IRQ_BIT = IRQ_BASE + CHAN_IDX;

  logic [CFG_W-1:0] cfg_q;
  logic flg_evt_q, flg_tgt_q, flg_ovf_q, fired_q, irq_q;
  logic qualify, issue;

  always_comb begin
    qualify = (evt_in.tgt && cfg_q[MB_IRQ_TGT]) || (evt_in.ovf && cfg_q[MB_IRQ_OVF]);
    issue   = qualify && (cfg_q[MB_IRQ_RPT] || !fired_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      flg_evt_q <= 1'b0;
      flg_tgt_q <= 1'b0;
      flg_ovf_q <= 1'b0;
      fired_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else if (mode_wr) begin
      cfg_q     <= mode_wdata;
      flg_evt_q <= 1'b0;
      flg_tgt_q <= 1'b0;
      flg_ovf_q <= 1'b0;
      fired_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q     <= issue;
      if (issue) fired_q <= 1'b1;
      flg_evt_q <= flg_evt_q || evt_in.tgt || evt_in.ovf;
      if (evt_in.tgt)   flg_tgt_q <= 1'b1;
      else if (mode_rd) flg_tgt_q <= 1'b0;
      if (evt_in.ovf)   flg_ovf_q <= 1'b1;
      else if (mode_rd) flg_ovf_q <= 1'b0;
    end
  end

  always_comb begin
    mode_q             = '0;
    mode_q[CFG_W-1:0]  = cfg_q;
    mode_q[MB_EVT]     = flg_evt_q;
    mode_q[MB_FLG_TGT] = flg_tgt_q;
    mode_q[MB_FLG_OVF] = flg_ovf_q;
    irq_vec            = '0;
    irq_vec[IRQ_BIT]   = irq_q;
  end

  assert_irq_once_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !cfg_q[MB_IRQ_RPT]) |=> !irq_q)
    else $error("one-shot interrupt fired twice");

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(evt_in.tgt || evt_in.ovf))
    else $error("interrupt without a preceding event");

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_rd && !mode_wr && !evt_in.tgt) |=> !flg_tgt_q)
    else $error("target flag survived a mode read");

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    evt_in.tgt |=> (flg_tgt_q && flg_evt_q))
    else $error("target event not recorded");

endmodule

// File: rtl/prog_root_timer.sv
module prog_root_timer
  import rtmr_pkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 2,
  parameter int DIV_LOG2 = 3,
  parameter int IRQ_W    = 8,
  parameter int IRQ_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_ce,
  input  logic              pix_ce,
  input  logic              hsync_pulse,
  output logic [IRQ_W-1:0]  irq_vec
);

  reg_sel_e          sel;
  logic              wr, rd;
  logic              cnt_wr, mode_wr, mode_rd, tgt_wr;
  logic [CNT_W-1:0]  target_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic              tick;
  evt_t              evt;
  logic              unused_ok;

  assign sel       = reg_sel_e'(bus_addr[1:0]);
  assign wr        = bus_en && bus_we;
  assign rd        = bus_en && !bus_we;
  assign cnt_wr    = wr && (sel == REG_COUNT);
  assign mode_wr   = wr && (sel == REG_MODE);
  assign tgt_wr    = wr && (sel == REG_TARGET);
  assign mode_rd   = rd && (sel == REG_MODE);
  assign unused_ok = ^bus_wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst)         target_q <= '0;
    else if (tgt_wr) target_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) begin
      unique case (sel)
        REG_COUNT:  bus_rdata <= DATA_W'(cnt_q);
        REG_MODE:   bus_rdata <= DATA_W'(mode_q);
        REG_TARGET: bus_rdata <= DATA_W'(target_q);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  rtmr_clk_sel #(.CHAN_IDX(CHAN_IDX), .DIV_LOG2(DIV_LOG2)) u_clk_sel (
    .clk(clk), .rst(rst), .mode_wr(mode_wr),
    .ctl_stop(mode_q[MB_STOP]), .ctl_alt(mode_q[MB_ALT]), .ctl_div(mode_q[MB_DIV]),
    .sys_ce(sys_ce), .pix_ce(pix_ce), .hsync_pulse(hsync_pulse), .tick(tick)
  );

  rtmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tick(tick), .clr(mode_wr),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata[CNT_W-1:0]),
    .rst_at_tgt(mode_q[MB_RST_TGT]), .target(target_q),
    .cnt_q(cnt_q), .evt(evt)
  );

  rtmr_ctrl #(.CHAN_IDX(CHAN_IDX), .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .mode_wr(mode_wr),
    .mode_wdata(bus_wdata[CFG_W-1:0]), .mode_rd(mode_rd),
    .evt_in(evt), .mode_q(mode_q), .irq_vec(irq_vec)
  );

  generate
    if (CHAN_IDX == 2) begin : g_stop_chk
      // R11: a stopped channel 2 keeps its count unless software writes it
      assert_stop_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_q[MB_STOP] && !cnt_wr && !mode_wr) |=> $stable(cnt_q))
        else $error("stopped channel kept counting");
    end
  endgenerate

endmodule

// File: tb/prog_root_timer_tb.sv
module prog_root_timer_tb;

  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [2:0]    bus_en    = '0;
  logic          bus_we    = 1'b0;
  logic [1:0]    bus_addr  = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          sys_ce    = 1'b0;
  logic          pix_ce    = 1'b0;
  logic          hsync     = 1'b0;
  logic [DW-1:0] rd0, rd1, rd2;
  logic [7:0]    iv0, iv1, iv2;

  prog_root_timer #(.CHAN_IDX(2)) u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en[2]), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd2), .sys_ce(sys_ce), .pix_ce(pix_ce),
    .hsync_pulse(hsync), .irq_vec(iv2));
  prog_root_timer #(.CHAN_IDX(0)) u_ch0 (
    .clk(clk), .rst(rst), .bus_en(bus_en[0]), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .sys_ce(sys_ce), .pix_ce(pix_ce),
    .hsync_pulse(hsync), .irq_vec(iv0));
  prog_root_timer #(.CHAN_IDX(1)) u_ch1 (
    .clk(clk), .rst(rst), .bus_en(bus_en[1]), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .sys_ce(sys_ce), .pix_ce(pix_ce),
    .hsync_pulse(hsync), .irq_vec(iv1));

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int            dev;
    logic [DW-1:0] exp;
    string         tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  int   irq_cnt[3];
  int   irq_mark[3];
  int   irq_stray = 0;
  logic rd_flag   = 1'b0;

  function automatic logic [DW-1:0] pick_rd(int d);
    if (d == 0)      return rd0;
    else if (d == 1) return rd1;
    else             return rd2;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compares each registered read result with the scoreboard head
  always @(posedge clk) rd_flag <= (|bus_en) && !bus_we;

  always @(negedge clk) begin
    if (rd_flag) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", rd2);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (pick_rd(it.dev) !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, pick_rd(it.dev), it.exp);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (iv0[4]) irq_cnt[0]++;
      if (iv1[5]) irq_cnt[1]++;
      if (iv2[6]) irq_cnt[2]++;
      if ((iv0 & ~8'h10) != 0 || (iv1 & ~8'h20) != 0 || (iv2 & ~8'h40) != 0) irq_stray++;
    end
  end

  task automatic bus_write(int dev, logic [1:0] a, logic [DW-1:0] d, bit with_tick = 1'b0);
    bus_en = 3'(1 << dev); bus_we = 1'b1; bus_addr = a; bus_wdata = d; sys_ce = with_tick;
    @(negedge clk);
    bus_en = '0; bus_we = 1'b0; sys_ce = 1'b0;
  endtask

  task automatic bus_read(int dev, logic [1:0] a, logic [DW-1:0] e, string tag,
                          bit with_tick = 1'b0);
    sb_item_t it;
    it.dev = dev; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_en = 3'(1 << dev); bus_we = 1'b0; bus_addr = a; sys_ce = with_tick;
    @(negedge clk);
    bus_en = '0; sys_ce = 1'b0;
  endtask

  // src: 0 = sys_ce, 1 = pix_ce, 2 = hsync
  task automatic pulse(int src, int n);
    if (n > 0) begin
      if (src == 0) sys_ce = 1'b1;
      else if (src == 1) pix_ce = 1'b1;
      else hsync = 1'b1;
      repeat (n) @(negedge clk);
      sys_ce = 1'b0; pix_ce = 1'b0; hsync = 1'b0;
    end
  endtask

  task automatic irq_expect(int dev, int delta, string tag);
    repeat (2) @(negedge clk);
    #1;
    check((irq_cnt[dev] - irq_mark[dev]) == delta, tag, irq_cnt[dev] - irq_mark[dev], delta);
    irq_mark[dev] = irq_cnt[dev];
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_read(2, 2'd0, 32'h0, "R1 count after reset");
    bus_read(2, 2'd1, 32'h0, "R1 mode after reset");
    bus_read(2, 2'd2, 32'h0, "R1 target after reset");

    // R2 system clock counting
    bus_write(2, 2'd1, 32'h0);
    pulse(0, 5);
    bus_read(2, 2'd0, 32'd5, "R2 count after 5 sys ticks");

    // R3 write widths and address map
    bus_write(2, 2'd0, 32'h1234_ABCD);
    bus_read(2, 2'd0, 32'h0000_ABCD, "R3 count keeps low 16 bits");
    bus_write(2, 2'd2, 32'hDEAD_0042);
    bus_read(2, 2'd2, 32'h0000_0042, "R3 target readback");
    bus_read(2, 2'd3, 32'h0, "R3 unused address");

    // R4 reset at target, one-shot (R7), flag read clear (R8)
    bus_write(2, 2'd2, 32'd3);
    bus_write(2, 2'd1, 32'h18);
    pulse(0, 3);
    bus_read(2, 2'd0, 32'd3, "R4 count reaches target");
    pulse(0, 1);
    bus_read(2, 2'd0, 32'd0, "R4 count folds to zero after target");
    pulse(0, 3);
    irq_expect(2, 1, "R7 one-shot gives a single pulse");
    bus_read(2, 2'd1, 32'h0C18, "R8 mode shows target and event flags");
    bus_read(2, 2'd1, 32'h0418, "R8 read cleared target flag, event bit stays");

    // R7 repeat mode
    bus_write(2, 2'd1, 32'h58);
    pulse(0, 8);
    irq_expect(2, 2, "R7 repeat gives pulse per event");
    bus_read(2, 2'd0, 32'd0, "R4 count after two folds");

    // R9 mode write re-arms one-shot
    bus_write(2, 2'd1, 32'h18);
    pulse(0, 3);
    irq_expect(2, 1, "R9 mode write re-arms one-shot");

    // R4 pass-through with bit 3 clear
    bus_write(2, 2'd1, 32'h10);
    pulse(0, 5);
    bus_read(2, 2'd0, 32'd5, "R4 count passes target");
    bus_read(2, 2'd1, 32'h0C10, "R4 target flag without fold");
    irq_expect(2, 1, "R6 target interrupt with bit 3 clear");

    // R5 overflow
    bus_write(2, 2'd1, 32'h20);
    bus_write(2, 2'd0, 32'hFFFE);
    pulse(0, 1);
    bus_read(2, 2'd0, 32'hFFFF, "R5 count at 0xFFFF");
    pulse(0, 1);
    bus_read(2, 2'd0, 32'h0, "R5 count wraps to zero");
    bus_read(2, 2'd1, 32'h1420, "R5 overflow flag set");
    irq_expect(2, 1, "R6 overflow interrupt");

    // R9 high bits read zero
    bus_write(2, 2'd1, 32'hE3FF);
    bus_read(2, 2'd1, 32'h03FF, "R9 bits 15:10 not writable");

    // R8 event in the same cycle as a mode read
    bus_write(2, 2'd1, 32'h0);
    bus_write(2, 2'd2, 32'd2);
    pulse(0, 1);
    bus_read(2, 2'd1, 32'h0, "R8 read returns pre-event value", 1'b1);
    bus_read(2, 2'd1, 32'h0C00, "R8 same-cycle event kept its flag");
    bus_read(2, 2'd1, 32'h0400, "R8 second read cleared flag");

    // R12 write priority over tick
    bus_write(2, 2'd0, 32'h100, 1'b1);
    bus_read(2, 2'd0, 32'h100, "R12 count write beats tick");
    bus_write(2, 2'd1, 32'h0, 1'b1);
    bus_read(2, 2'd0, 32'h0, "R12 mode write beats tick");

    // R11 divide by eight and stop
    bus_write(2, 2'd1, 32'h200);
    pulse(0, 7);
    bus_read(2, 2'd0, 32'd0, "R11 no tick before 8th enable");
    pulse(0, 1);
    bus_read(2, 2'd0, 32'd1, "R11 tick on 8th enable");
    pulse(0, 16);
    bus_read(2, 2'd0, 32'd3, "R11 two more divided ticks");
    bus_write(2, 2'd1, 32'h201);
    pulse(0, 10);
    bus_read(2, 2'd0, 32'd0, "R11 stop bit with divider");
    bus_write(2, 2'd1, 32'h001);
    pulse(0, 5);
    bus_read(2, 2'd0, 32'd0, "R11 stop bit alone");

    // R10 alternate sources
    bus_write(2, 2'd1, 32'h100);
    pulse(1, 4);
    pulse(2, 4);
    bus_read(2, 2'd0, 32'd0, "R10 channel 2 ignores alternate sources");
    pulse(0, 3);
    bus_read(2, 2'd0, 32'd3, "R10 channel 2 bit 8 keeps system clock");

    bus_write(0, 2'd1, 32'h100);
    pulse(0, 4);
    pulse(2, 2);
    pulse(1, 6);
    bus_read(0, 2'd0, 32'd6, "R10 channel 0 counts pixel enables");
    bus_write(1, 2'd1, 32'h100);
    pulse(2, 2);
    pulse(0, 3);
    pulse(1, 3);
    bus_read(1, 2'd0, 32'd2, "R10 channel 1 counts hsync");
    bus_write(1, 2'd1, 32'h0);
    pulse(2, 3);
    pulse(0, 2);
    bus_read(1, 2'd0, 32'd2, "R10 channel 1 bit 8 clear uses system clock");

    // R6 interrupt bit position on channel 0
    bus_write(0, 2'd2, 32'd2);
    bus_write(0, 2'd1, 32'h118);
    pulse(1, 2);
    irq_expect(0, 1, "R6 channel 0 interrupt on bit 4");
    irq_expect(1, 0, "R6 channel 1 silent");

    repeat (4) @(negedge clk);
    check(irq_stray == 0, "R6 no interrupt outside channel bit", irq_stray, 0);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end

endmodule